// File: doc/BRIEF.md
# Ordered Store Buffer with Load Forwarding

This block sits between one core and a shared memory. Every store the core issues goes into a small circular queue. The queue then writes its entries out to shared memory one at a time, oldest first. Until an entry has left the queue, other agents that read shared memory cannot see that store. The owning core still sees it, because each core load first searches the queue. If one or more queued entries hold the same address, the newest of them supplies the data. If none match, the load reads shared memory through a combinational read port.

The result is total store order. Stores reach memory in the order the core issued them. A later load may finish while earlier stores are still queued. A fence request holds back new loads and stores until the queue has emptied completely, and then reports completion.

The store push and the drain are both valid/ready streams. A push is taken only in a cycle where `st_valid` and `st_ready` are both high. `st_ready` drops while the queue is full or while a fence is waiting. A drain entry leaves the queue only in a cycle where `dr_valid` and `dr_ready` are both high. While `dr_ready` is low, the head entry is held unchanged on the drain port.

Top module: `tso_store_buffer`

## Requirements
- R1: After reset the queue is empty: `dr_valid` is 0, `st_ready` is 1, `ld_hit` is 0 and `fence_done` is 0.
- R2: An accepted store is not written to memory directly. Shared memory receives a store only through a drain handshake, and the drain port always presents the oldest queued entry.
- R3: Entries drain in the order they were pushed. While `dr_valid` is 1 and `dr_ready` is 0, `dr_addr` and `dr_data` stay unchanged.
- R4: An entry is removed only in a cycle with both `dr_valid` and `dr_ready` high. `dr_valid` is 1 exactly when the queue holds at least one entry.
- R5: A valid load whose address matches queued entries sets `ld_hit` to 1 and returns the data of the most recently pushed matching entry. Shared memory is not read (`mem_rd_en` is 0).
- R6: A valid load with no matching entry sets `ld_hit` to 0. It drives `mem_rd_addr` equal to `ld_addr`, returns `mem_rd_data` and raises `mem_rd_en`.
- R7: With no fence pending, `ld_ready` is 1 even while stores are queued, so a load may complete ahead of older buffered stores.
- R8: While the queue holds DEPTH entries, `st_ready` is 0. A push offered in the same cycle as a drain handshake at full is still refused, and the occupancy then drops by exactly one.
- R9: While `fence_req` is 1 and the queue is not empty, `st_ready`, `ld_ready` and `fence_done` are all 0. `fence_done` is 1 when `fence_req` is 1 and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Core offers a store |
| st_ready | output | 1 | Buffer accepts the store this cycle |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| ld_valid | input | 1 | Core issues a load |
| ld_ready | output | 1 | Load may complete this cycle |
| ld_addr | input | ADDR_W | Load address |
| ld_data | output | DATA_W | Load result (forwarded or from memory) |
| ld_hit | output | 1 | Load result came from the buffer |
| mem_rd_en | output | 1 | Load reads shared memory this cycle |
| mem_rd_addr | output | ADDR_W | Shared memory read address |
| mem_rd_data | input | DATA_W | Shared memory read data (combinational) |
| dr_valid | output | 1 | Head entry offered to shared memory |
| dr_ready | input | 1 | Shared memory takes the head entry |
| dr_addr | output | ADDR_W | Head entry address |
| dr_data | output | DATA_W | Head entry data |
| fence_req | input | 1 | Core requests a fence |
| fence_done | output | 1 | Fence complete: buffer empty |

## Verification
The assertions take for granted that the core only presents a store while it can see `st_ready`. They also assume memory reads are combinational, so a load completes in the cycle it is issued. The bench drives every input half a cycle away from the clock edge. It keeps `mem_rd_data` as a pure function of `mem_rd_addr` over a bench-held memory image, and that image is updated only on drain handshakes. The stimulus includes pushes at full, drains with `dr_ready` toggling and fences with stores still queued. It finishes with a sweep that combines push, drain, load address and fence on every cycle.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  localparam int TSB_DEPTH_DEF = 8;
  localparam int TSB_ADDR_DEF  = 16;
  localparam int TSB_DATA_DEF  = 32;
endpackage

// File: rtl/tsb_fifo.sv
module tsb_fifo #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [ADDR_W-1:0] ent_addr [DEPTH],
  output logic [DATA_W-1:0] ent_data [DEPTH],
  output logic [PTR_W-1:0]  head_ptr,
  output logic [CNT_W-1:0]  level
);
  logic [PTR_W-1:0] tail_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_ptr <= '0;
      tail_ptr <= '0;
      level    <= '0;
    end else begin
      if (push) tail_ptr <= tail_ptr + 1'b1;
      if (pop)  head_ptr <= head_ptr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      ent_addr[tail_ptr] <= push_addr;
      ent_data[tail_ptr] <= push_data;
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH));

  // R8
  full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == CNT_W'(DEPTH)) |-> !push);

  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> !pop);
endmodule

// File: rtl/tsb_match.sv
module tsb_match #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [ADDR_W-1:0] ent_addr [DEPTH],
  input  logic [DATA_W-1:0] ent_data [DEPTH],
  input  logic [PTR_W-1:0]  head_ptr,
  input  logic [CNT_W-1:0]  level,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              hit,
  output logic [DATA_W-1:0] hit_data
);
  logic [PTR_W-1:0] idx;

  // Walk from oldest to newest; a later match overrides, so the youngest wins.
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    idx      = head_ptr;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_ptr + PTR_W'(k);
      if ((CNT_W'(k) < level) && (ent_addr[idx] == look_addr)) begin
        hit      = 1'b1;
        hit_data = ent_data[idx];
      end
    end
  end
endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer #(
  parameter int DEPTH  = tsb_pkg::TSB_DEPTH_DEF,
  parameter int ADDR_W = tsb_pkg::TSB_ADDR_DEF,
  parameter int DATA_W = tsb_pkg::TSB_DATA_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic [DATA_W-1:0] ld_data,
  output logic              ld_hit,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              dr_valid,
  input  logic              dr_ready,
  output logic [ADDR_W-1:0] dr_addr,
  output logic [DATA_W-1:0] dr_data,
  input  logic              fence_req,
  output logic              fence_done
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [DATA_W-1:0] ent_data [DEPTH];
  logic [PTR_W-1:0]  head_ptr;
  logic [CNT_W-1:0]  level;
  logic              push, pop, is_empty, is_full, fence_wait;
  logic              fwd_hit;
  logic [DATA_W-1:0] fwd_data;

  assign is_empty   = (level == '0);
  assign is_full    = (level == CNT_W'(DEPTH));
  assign fence_wait = fence_req && !is_empty;
  assign st_ready   = !is_full && !fence_wait;
  assign ld_ready   = !fence_wait;
  assign fence_done = fence_req && is_empty;
  assign push       = st_valid && st_ready;
  assign dr_valid   = !is_empty;
  assign pop        = dr_valid && dr_ready;
  assign dr_addr    = ent_addr[head_ptr];
  assign dr_data    = ent_data[head_ptr];

  tsb_fifo #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(push), .push_addr(st_addr),
    .push_data(st_data), .pop(pop), .ent_addr(ent_addr),
    .ent_data(ent_data), .head_ptr(head_ptr), .level(level)
  );

  tsb_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) match_i (
    .ent_addr(ent_addr), .ent_data(ent_data), .head_ptr(head_ptr),
    .level(level), .look_addr(ld_addr), .hit(fwd_hit), .hit_data(fwd_data)
  );

  assign mem_rd_addr = ld_addr;
  assign ld_hit      = ld_valid && fwd_hit;
  assign mem_rd_en   = ld_valid && ld_ready && !fwd_hit;
  assign ld_data     = fwd_hit ? fwd_data : mem_rd_data;

  // R3
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_addr) && $stable(dr_data)));

  // R9
  fence_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_req && dr_valid) |-> (!st_ready && !ld_ready && !fence_done));

  // R5
  empty_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dr_valid |-> !ld_hit);

  // R6
  one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hit && mem_rd_en));
endmodule

// File: tb/tso_store_buffer_tb_top.sv
module tso_store_buffer_tb_top;
  localparam int DEPTH = 4;
  localparam int AW = 3;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 1'b0, ld_valid = 1'b0, dr_ready = 1'b0, fence_req = 1'b0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic st_ready, ld_ready, ld_hit, mem_rd_en, dr_valid, fence_done;
  logic [DW-1:0] ld_data, dr_data, mem_rd_data;
  logic [AW-1:0] mem_rd_addr, dr_addr;

  logic [DW-1:0] mem [8];
  logic [AW-1:0] m_addr [DEPTH];
  logic [DW-1:0] m_data [DEPTH];
  int mcnt = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign mem_rd_data = mem[mem_rd_addr];

  tso_store_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .ld_valid(ld_valid),
    .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_data(ld_data),
    .ld_hit(ld_hit), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .dr_valid(dr_valid), .dr_ready(dr_ready),
    .dr_addr(dr_addr), .dr_data(dr_data), .fence_req(fence_req),
    .fence_done(fence_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                     input bit dr, input bit fr, input bit lv, input logic [AW-1:0] la);
    bit e_full, e_fw, e_st, e_hit, e_pop;
    logic [DW-1:0] e_ld;
    st_valid = sv; st_addr = sa; st_data = sd; dr_ready = dr;
    fence_req = fr; ld_valid = lv; ld_addr = la;
    #5;
    e_full = (mcnt == DEPTH);
    e_fw   = fr && (mcnt != 0);
    e_st   = !e_full && !e_fw;
    e_hit  = 0;
    e_ld   = mem[la];
    for (int k = 0; k < mcnt; k++)
      if (m_addr[k] == la) begin e_hit = 1; e_ld = m_data[k]; end
    chk("R8 R9 st_ready", 32'(st_ready), 32'(e_st));
    chk("R7 R9 ld_ready", 32'(ld_ready), 32'(!e_fw));
    chk("R9 fence_done", 32'(fence_done), 32'(fr && mcnt == 0));
    chk("R4 dr_valid", 32'(dr_valid), 32'(mcnt != 0));
    if (mcnt != 0) begin
      chk("R2 R3 dr_addr", 32'(dr_addr), 32'(m_addr[0]));
      chk("R2 R3 dr_data", 32'(dr_data), 32'(m_data[0]));
    end
    chk("R5 R6 ld_hit", 32'(ld_hit), 32'(lv && e_hit));
    chk("R6 mem_rd_en", 32'(mem_rd_en), 32'(lv && !e_fw && !e_hit));
    chk("R6 mem_rd_addr", 32'(mem_rd_addr), 32'(la));
    if (lv) chk("R5 R6 ld_data", 32'(ld_data), 32'(e_ld));
    e_pop = dr && (mcnt != 0);
    @(posedge clk);
    if (e_pop) begin
      mem[m_addr[0]] = m_data[0];
      for (int k = 0; k < DEPTH - 1; k++) begin
        m_addr[k] = m_addr[k+1];
        m_data[k] = m_data[k+1];
      end
      mcnt--;
    end
    if (sv && e_st) begin
      m_addr[mcnt] = sa; m_data[mcnt] = sd; mcnt++;
    end
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mem[i] = 8'(i * 29 + 5);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    #5;
    chk("R1 dr_valid", 32'(dr_valid), 0);
    chk("R1 st_ready", 32'(st_ready), 1);
    chk("R1 ld_hit", 32'(ld_hit), 0);
    chk("R1 fence_done", 32'(fence_done), 0);
    @(negedge clk);
    // R2 R5 R6 R7: fill with duplicate addresses, sweep loads
    cyc(1, 3'd2, 8'hA1, 0, 0, 1, 3'd2);
    cyc(1, 3'd5, 8'hB2, 0, 0, 1, 3'd2);
    cyc(1, 3'd2, 8'hC3, 0, 0, 1, 3'd5);
    cyc(1, 3'd7, 8'hD4, 0, 0, 1, 3'd2);
    for (int a = 0; a < 8; a++) cyc(0, 0, 0, 0, 0, 1, 3'(a));
    // R8: push at full refused, also with a same-cycle drain
    cyc(1, 3'd1, 8'hEE, 0, 0, 0, 0);
    cyc(1, 3'd1, 8'hEF, 1, 0, 1, 3'd1);
    cyc(1, 3'd1, 8'hF0, 0, 0, 1, 3'd1);
    cyc(1, 3'd3, 8'hF1, 0, 0, 0, 0);
    // R3 R4: drain with stalling ready
    for (int i = 0; i < 16; i++) cyc(0, 0, 0, (i % 3) != 1, 0, 1, 3'(i));
    for (int a = 0; a < 8; a++) cyc(0, 0, 0, 0, 0, 1, 3'(a));
    // R9: fence with queued stores and store attempts
    cyc(1, 3'd4, 8'h11, 0, 0, 0, 0);
    cyc(1, 3'd6, 8'h22, 0, 0, 0, 0);
    cyc(1, 3'd4, 8'h33, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) cyc(1, 3'd0, 8'h44, i[0], 1, 1, 3'd4);
    cyc(0, 0, 0, 0, 0, 1, 3'd4);
    // R3 R5 R6 R8 R9: combined sweep
    for (int p = 0; p < 512; p++)
      cyc(p[0], 3'(p >> 2), 8'(p * 7 + 1), p[1], (p % 16) == 15, 1, 3'(p >> 5));
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1, 0, 0, 0);
    chk("R4 final empty", 32'(dr_valid), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule